// File: doc/BRIEF.md
# Framed Serial Word Steering Engine

This block sits behind a snapshot FIFO and turns each stored snapshot (a timestamp plus one hit/no-hit bit per channel) into a continuous serial stream. The stream is built from fixed-length words. Each word is one leading marker bit, one data byte and a two-bit type code, sent most significant bit first, one bit per clock. The serial clock therefore runs at the word length times the word rate.

With the FIFO empty, the line carries a Sync word and a Status word, one after the other, indefinitely. Whenever a snapshot is waiting, it is sent with no request from outside. After the next Sync word, the block pops the FIFO and sends a frame: the timestamp bytes first, then the hit bytes. After every frame it sends a Sync word again. It then starts another frame if the FIFO still holds data, and otherwise goes back to Status.

The FIFO is read in show-ahead style. The head entry is visible on `fifo_rd_data` while `fifo_empty` is low, and the entry is consumed on a clock edge where `fifo_rd_en` is high.

Top module: `steer_serializer`

## Requirements
- R1: Every word is WORD_LEN = BYTE_W+3 bits (11 by default). Words are sent back to back, one bit per clock, in this order: a marker bit that is always 1, then data bits D7 down to D0, then type bits T1 and T0. The first word after reset starts in the first clock after `rst_n` rises.
- R2: The type field is 00 for Sync, 01 for Hit, 10 for Time and 11 for Status.
- R3: A Sync word always carries an all-zero data byte.
- R4: While the FIFO stays empty, Sync and Status words alternate, starting with the Sync word that follows reset.
- R5: A frame begins only right after a Sync word. It is 11 words long: 3 Time words, then 8 Hit words.
- R6: The Time words carry snapshot bits [87:64] (the timestamp), most significant byte first.
- R7: The Hit words carry snapshot bits [63:0], taking bits [63:56] first and bits [7:0] last.
- R8: `fifo_rd_en` is high for exactly one clock per frame: the last bit clock of the Sync word that precedes the frame. It is only raised when `fifo_empty` is low, and the snapshot for the frame is the value on `fifo_rd_data` in that clock.
- R9: A Sync word follows each frame. After that Sync word, a further frame follows if the FIFO is non-empty, and a Status word follows if it is empty.
- R10: A Status word carries `status_flags` as sampled in the last bit clock of the preceding Sync word.
- R11: While `rst_n` is low, `ser_out` is 1 and `fifo_rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | FIFO holds no snapshot |
| fifo_rd_data | input | 88 | Head snapshot: timestamp in [87:64], hits in [63:0] |
| fifo_rd_en | output | 1 | Pop strobe for the FIFO head |
| status_flags | input | 8 | Flags (accept, pipeline on, trigger source, and others) placed in Status words |
| ser_out | output | 1 | Serial word stream |

## Verification
The bench builds the block with its default parameters: a 24-bit stamp, 64 hit bits and byte-wide data. That gives 11-bit words and 11-word frames, the same as the deployed format. A behavioural model in the bench predicts every serial bit and the pop strobe on every clock. With these parameters the stimulus reaches long idle runs, a single frame, three snapshots queued back to back, a snapshot that arrives while a frame is in flight, and a change of the status flags between two Status words.

// File: rtl/steer_pkg.sv
package steer_pkg;
   // Word kinds; the encoding is the type field sent on the line.
   typedef enum logic [1:0] {
      WK_SYNC   = 2'b00,
      WK_HIT    = 2'b01,
      WK_TIME   = 2'b10,
      WK_STATUS = 2'b11
   } word_kind_e;
endpackage

// File: rtl/steer_word_timer.sv
module steer_word_timer #(
   parameter int WORD_LEN = 11
) (
   input  logic clk,
   input  logic rst_n,
   output logic last_bit
);
   localparam int CNT_W = $clog2(WORD_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_LEN - 1);

   logic [CNT_W-1:0] bit_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)               bit_cnt <= '0;
      else if (bit_cnt == LAST) bit_cnt <= '0;
      else                      bit_cnt <= bit_cnt + CNT_W'(1);
   end

   assign last_bit = (bit_cnt == LAST);

   AST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      last_bit |=> (bit_cnt == '0)); // R1
endmodule

// File: rtl/steer_sequencer.sv
module steer_sequencer
   import steer_pkg::*;
#(
   parameter int N_TIME  = 3,
   parameter int N_WORDS = 11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       last_bit,
   input  logic                       fifo_empty,
   output logic                       pop,
   output word_kind_e                 nxt_kind,
   output logic [$clog2(N_WORDS)-1:0] nxt_idx
);
   localparam int IDX_W = $clog2(N_WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

   word_kind_e       cur_kind;
   logic [IDX_W-1:0] cur_idx;
   logic [IDX_W-1:0] inc_idx;

   assign inc_idx = cur_idx + IDX_W'(1);

   always_comb begin
      nxt_kind = cur_kind;
      nxt_idx  = cur_idx;
      pop      = 1'b0;
      unique case (cur_kind)
         WK_SYNC: begin
            nxt_idx = '0;
            if (!fifo_empty) begin
               nxt_kind = WK_TIME;
               pop      = last_bit;
            end else begin
               nxt_kind = WK_STATUS;
            end
         end
         WK_STATUS: begin
            nxt_kind = WK_SYNC;
            nxt_idx  = '0;
         end
         default: begin
            if (cur_idx == LAST_IDX) begin
               nxt_kind = WK_SYNC;
               nxt_idx  = '0;
            end else begin
               nxt_idx  = inc_idx;
               nxt_kind = (inc_idx < IDX_W'(N_TIME)) ? WK_TIME : WK_HIT;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_kind <= WK_SYNC;
         cur_idx  <= '0;
      end else if (last_bit) begin
         cur_kind <= nxt_kind;
         cur_idx  <= nxt_idx;
      end
   end

   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !fifo_empty); // R8
   AST_FRAME_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (cur_kind == WK_TIME && cur_idx == '0)); // R5
   AST_IDLE_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && cur_kind == WK_STATUS) |=> (cur_kind == WK_SYNC)); // R4
   AST_FRAME_END_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && cur_kind == WK_HIT && cur_idx == LAST_IDX) |=> (cur_kind == WK_SYNC)); // R9
endmodule

// File: rtl/steer_word_builder.sv
module steer_word_builder
   import steer_pkg::*;
#(
   parameter int SNAP_W  = 88,
   parameter int BYTE_W  = 8,
   parameter int N_WORDS = 11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pop,
   input  word_kind_e                 nxt_kind,
   input  logic [$clog2(N_WORDS)-1:0] nxt_idx,
   input  logic [SNAP_W-1:0]          fifo_rd_data,
   input  logic [BYTE_W-1:0]          status_flags,
   output logic [BYTE_W+2:0]          word
);
   localparam int IDX_W = $clog2(N_WORDS);

   logic [SNAP_W-1:0] snap;
   logic [SNAP_W-1:0] src;
   logic [BYTE_W-1:0] byte_arr [N_WORDS];
   logic [BYTE_W-1:0] data;

   always_ff @(posedge clk) begin
      if (!rst_n)   snap <= '0;
      else if (pop) snap <= fifo_rd_data;
   end

   // The first frame word is built straight from the FIFO head.
   assign src = pop ? fifo_rd_data : snap;

   for (genvar g = 0; g < N_WORDS; g++) begin : g_slice
      assign byte_arr[g] = src[SNAP_W-1-g*BYTE_W -: BYTE_W];
   end

   always_comb begin
      data = '0;
      unique case (nxt_kind)
         WK_SYNC:   data = '0;
         WK_STATUS: data = status_flags;
         default: begin
            for (int i = 0; i < N_WORDS; i++)
               if (nxt_idx == IDX_W'(i)) data = byte_arr[i];
         end
      endcase
   end

   assign word = {1'b1, data, nxt_kind};
endmodule

// File: rtl/steer_shifter.sv
module steer_shifter #(
   parameter int WORD_LEN = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [WORD_LEN-1:0] word,
   output logic                ser_out
);
   localparam logic [WORD_LEN-1:0] SYNC_WORD = {1'b1, {(WORD_LEN-1){1'b0}}};

   logic [WORD_LEN-1:0] sr;

   always_ff @(posedge clk) begin
      if (!rst_n)    sr <= SYNC_WORD;
      else if (load) sr <= word;
      else           sr <= {sr[WORD_LEN-2:0], 1'b0};
   end

   assign ser_out = sr[WORD_LEN-1];

   AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ser_out); // R1
endmodule

// File: rtl/steer_serializer.sv
module steer_serializer
   import steer_pkg::*;
#(
   parameter int TS_W   = 24,
   parameter int HIT_W  = 64,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fifo_empty,
   input  logic [TS_W+HIT_W-1:0]   fifo_rd_data,
   output logic                    fifo_rd_en,
   input  logic [BYTE_W-1:0]       status_flags,
   output logic                    ser_out
);
   localparam int SNAP_W   = TS_W + HIT_W;
   localparam int N_TIME   = TS_W / BYTE_W;
   localparam int N_WORDS  = SNAP_W / BYTE_W;
   localparam int WORD_LEN = BYTE_W + 3;
   localparam int IDX_W    = $clog2(N_WORDS);

   if (TS_W % BYTE_W != 0) begin : g_bad_ts
      $error("TS_W must be a whole number of bytes");
   end
   if (HIT_W % BYTE_W != 0) begin : g_bad_hit
      $error("HIT_W must be a whole number of bytes");
   end
   if (N_TIME < 1 || HIT_W < BYTE_W) begin : g_bad_frame
      $error("frame needs at least one Time and one Hit word");
   end

   logic              last_bit;
   logic              pop;
   word_kind_e        nxt_kind;
   logic [IDX_W-1:0]  nxt_idx;
   logic [WORD_LEN-1:0] word;

   steer_word_timer #(.WORD_LEN(WORD_LEN)) u_timer (
      .clk(clk), .rst_n(rst_n), .last_bit(last_bit));

   steer_sequencer #(.N_TIME(N_TIME), .N_WORDS(N_WORDS)) u_seq (
      .clk(clk), .rst_n(rst_n), .last_bit(last_bit), .fifo_empty(fifo_empty),
      .pop(pop), .nxt_kind(nxt_kind), .nxt_idx(nxt_idx));

   steer_word_builder #(.SNAP_W(SNAP_W), .BYTE_W(BYTE_W), .N_WORDS(N_WORDS)) u_build (
      .clk(clk), .rst_n(rst_n), .pop(pop), .nxt_kind(nxt_kind), .nxt_idx(nxt_idx),
      .fifo_rd_data(fifo_rd_data), .status_flags(status_flags), .word(word));

   steer_shifter #(.WORD_LEN(WORD_LEN)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(last_bit), .word(word), .ser_out(ser_out));

   assign fifo_rd_en = pop;

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!rst_n |-> (ser_out && !fifo_rd_en))); // R11
endmodule

// File: tb/steer_serializer_tb.sv
module steer_serializer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SNAP_W = 88;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fifo_empty = 1'b1;
   logic [SNAP_W-1:0] fifo_rd_data = '0;
   logic [7:0]        status_flags = 8'h05;
   logic              fifo_rd_en;
   logic              ser_out;

   steer_serializer u_dut (
      .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_rd_data(fifo_rd_data),
      .fifo_rd_en(fifo_rd_en), .status_flags(status_flags), .ser_out(ser_out));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails = 0;
   bit finished = 0;
   logic [SNAP_W-1:0] q[$];
   bit    ebits[$];
   string etags[$];
   int    kind_now;      // 0 sync, 1 status, 2 frame

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   // R1 layout: marker 1, data MSB first, type T1 T0 (R2 codes)
   task automatic push_word(input logic [7:0] data, input logic [1:0] t, input string dtag);
      ebits.push_back(1'b1); etags.push_back("R1");
      for (int i = 7; i >= 0; i--) begin
         ebits.push_back(data[i]); etags.push_back(dtag);
      end
      ebits.push_back(t[1]); etags.push_back("R2");
      ebits.push_back(t[0]); etags.push_back("R2");
   endtask

   task automatic refresh();
      fifo_empty   = (q.size() == 0);
      fifo_rd_data = (q.size() == 0) ? '0 : q[0];
   endtask

   initial begin : main
      bit b;
      string tg;
      bit pop_exp;
      logic [SNAP_W-1:0] snap;
      refresh();
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(ser_out == 1'b1, "R11 ser_out in reset", 32'(ser_out), 1);
      chk(fifo_rd_en == 1'b0, "R11 rd_en in reset", 32'(fifo_rd_en), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      push_word(8'h00, 2'b00, "R3");
      kind_now = 0;
      for (int cyc = 0; cyc < 1700; cyc++) begin
         @(negedge clk);
         b  = ebits.pop_front();
         tg = etags.pop_front();
         chk(ser_out == b, tg, 32'(ser_out), 32'(b));
         pop_exp = 1'b0;
         if (ebits.size() == 0) begin
            if (kind_now == 0) begin
               if (q.size() > 0) begin
                  // R5/R9: frame after Sync; R6 time bytes, R7 hit bytes
                  snap = q[0];
                  for (int w = 0; w < 11; w++)
                     push_word(snap[SNAP_W-1-8*w -: 8], (w < 3) ? 2'b10 : 2'b01, (w < 3) ? "R6" : "R7");
                  pop_exp  = 1'b1;
                  kind_now = 2;
               end else begin
                  // R4 idle alternation, R10 flags sampled now
                  push_word(status_flags, 2'b11, "R10");
                  kind_now = 1;
               end
            end else begin
               push_word(8'h00, 2'b00, "R3");
               kind_now = 0;
            end
         end
         chk(fifo_rd_en == pop_exp, "R8 pop strobe", 32'(fifo_rd_en), 32'(pop_exp));
         @(posedge clk); #1;
         if (pop_exp) void'(q.pop_front());
         if (cyc == 120) q.push_back(88'hA1B2C3_0123456789ABCDEF);            // R5 single frame
         if (cyc == 420) begin                                                  // R9 back to back
            q.push_back(88'h000001_8000000000000001);
            q.push_back(88'hFFFFFF_0000000000000000);
            q.push_back(88'h7E5A3C_FEDCBA9876543210);
         end
         if (cyc == 960)  status_flags = 8'h06;                                // R10 flag change
         if (cyc == 1100) q.push_back(88'h123456_FFFFFFFFFFFFFFFF);
         if (cyc == 1160) q.push_back(88'hC0FFEE_55AA55AA55AA55AA);           // arrives mid-frame
         refresh();
      end
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule